// File: doc/BRIEF.md
# Ident-Framed Serial Bus Slave

This block is the slave side of a three-line serial control bus. The lines are Ident, Clock and a shared open-drain Data line. The master pulls Ident low to frame an eight-bit device address, which is sent least significant bit first. Each bit is taken on a rising Clock edge. When Ident returns high, the slave compares the captured address with three recognised codes. A strap input selects which group of three codes is used. Each recognised code selects one command: load memory address, read, or program.

After a match the master sends 8 or 16 clocks of data, least significant bit first. For write-type commands the slave collects the bits into a 16-bit word. For a read, the slave sends a supplied byte on the first eight clocks by pulling Data low for each zero bit. A short low pulse on Ident then closes the transaction. When the pulse ends, the slave raises a one-cycle commit strobe and presents the command code, the received word and its length to the logic that owns the storage.

All three bus lines are double-synchronised to the system clock. Edges are detected by comparing each synchronised sample with the one before it. The bus is slow compared with the system clock, so one transaction may take any number of system cycles.

Top module: `ick_bus_slave`

## Requirements
- R1: After reset, `d_pull_low_o` is 0, `cmd_commit_o` is 0, `cmd_kind_o` is 0, `rx_word_o` is 0 and `rx_long_o` is 0.
- R2: With `opt_strap_i` low, the address is captured LSB first on rising Clock edges and compared when Ident rises. Address 128 gives command code 1 (load address), 129 gives code 2 (read) and 131 gives code 3 (program).
- R3: With `opt_strap_i` high, the recognised addresses are 132, 133 and 135, giving codes 1, 2 and 3. Every other address, including 128, 129 and 131, is unrecognised.
- R4: Data bits are stored LSB first in transfer order. A 16-bit transfer fills `rx_word_o[15:0]` and sets `rx_long_o` to 1. An 8-bit transfer fills `rx_word_o[7:0]`, clears `rx_word_o[15:8]` and sets `rx_long_o` to 0.
- R5: `cmd_commit_o` goes high for exactly one system cycle after Ident rises at the end of the closing low pulse. `cmd_kind_o`, `rx_word_o` and `rx_long_o` change only together with that strobe.
- R6: For a read, on data clock k (k = 0..7) the slave pulls Data low exactly when bit k of `rd_byte_i` is 0. On data clocks 8..15 it releases Data. The slave never drives Data high; `d_pull_low_o` = 1 means the line is pulled low.
- R7: After an unrecognised address the slave never pulls Data and never commits, until the next Ident falling edge starts a new address phase.
- R8: The slave has no timeout. A transaction that pauses for thousands of system cycles in the middle of its data phase still completes and commits normally.
- R9: A reset asserted in the middle of a transaction aborts it. The closing Ident pulse of that transaction produces no commit.
- R10: An address phase with other than 8 clocks, or a data phase with other than 8 or 16 clocks, produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; aborts any transaction |
| id_i | input | 1 | Ident line from the master (idle high) |
| cl_i | input | 1 | Bus Clock line from the master (idle high) |
| d_i | input | 1 | Sensed level of the shared Data line |
| d_pull_low_o | output | 1 | 1 = pull the Data line low; 0 = release it |
| opt_strap_i | input | 1 | Selects the recognised address group (low: 128/129/131, high: 132/133/135) |
| rd_byte_i | input | 8 | Byte sent during a read data phase |
| cmd_commit_o | output | 1 | One-cycle strobe when a transaction closes validly |
| cmd_kind_o | output | 2 | Committed command: 1 load address, 2 read, 3 program |
| rx_word_o | output | 16 | Data word received in the committed transaction |
| rx_long_o | output | 1 | 1 if the committed transfer had 16 data bits, 0 if it had 8 |

## Verification
The main sweep sends all 256 address values under both strap levels, each followed by an 8-bit data phase whose value depends on the address. This separates a correct decode from one that is off by one code, that ignores the strap, or that reverses bit order: exactly six of the 512 cases may commit, and each must carry its own code and data. Reads are tried with sixteen distinct byte patterns in both 8- and 16-clock forms. The bench samples the wired-AND line the way a master would, so it detects wrong bit order, a late bit, and driving outside the first byte. Separate cases cover the long pause, truncated address and data phases, an unrecognised address while the read byte is all zeros, and a reset in the middle of a transfer.

// File: rtl/ick_pkg.sv
package ick_pkg;

    localparam int ADDR_BITS = 8;
    localparam int NUM_CMDS  = 3;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_SETADR = 2'd1,
        CMD_READ   = 2'd2,
        CMD_PROG   = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ENDP,
        ST_SKIP
    } st_e;

    typedef struct packed {
        logic dat;
        logic cl;
        logic id;
    } lines_t;

    // offset of each recognised code above the strap-selected base
    function automatic logic [ADDR_BITS-1:0] cmd_offset(input int idx);
        case (idx)
            0:       cmd_offset = 8'd0;
            1:       cmd_offset = 8'd1;
            default: cmd_offset = 8'd3;
        endcase
    endfunction

    function automatic cmd_e cmd_of_index(input int idx);
        case (idx)
            0:       cmd_of_index = CMD_SETADR;
            1:       cmd_of_index = CMD_READ;
            default: cmd_of_index = CMD_PROG;
        endcase
    endfunction

endpackage

// File: rtl/ick_line_sync.sv
module ick_line_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe <= '1;
                prev <= 1'b1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw_i[g]};
                prev <= pipe[STAGES-1];
            end
        end

        assign lvl_o[g]  = pipe[STAGES-1];
        assign rise_o[g] = pipe[STAGES-1] & ~prev;
        assign fall_o[g] = ~pipe[STAGES-1] & prev;
    end

endmodule

// File: rtl/ick_shift_unit.sv
module ick_shift_unit #(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     take_i,
    input  logic                     bit_i,
    output logic [W-1:0]             word_o,
    output logic [$clog2(W+2)-1:0]   cnt_o
);

    localparam int CW = $clog2(W + 2);
    localparam int IW = $clog2(W);
    localparam logic [CW-1:0] CAP = CW'(W + 1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (take_i) begin
            if (cnt_o < CW'(W))
                word_o[cnt_o[IW-1:0]] <= bit_i;
            if (cnt_o < CAP)
                cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CAP); // R10

endmodule

// File: rtl/ick_addr_match.sv
module ick_addr_match
    import ick_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] BASE_LO = 8'd128,
    parameter logic [ADDR_BITS-1:0] BASE_HI = 8'd132
) (
    input  logic [ADDR_BITS-1:0] addr_i,
    input  logic                 strap_i,
    output logic [NUM_CMDS-1:0]  hit_o,
    output cmd_e                 kind_o
);

    logic [ADDR_BITS-1:0] base;
    assign base = strap_i ? BASE_HI : BASE_LO;

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_cmp
        assign hit_o[g] = (addr_i == base + cmd_offset(g));
    end

    always_comb begin
        kind_o = CMD_NONE;
        for (int i = 0; i < NUM_CMDS; i++)
            if (hit_o[i]) kind_o = cmd_of_index(i);
    end

endmodule

// File: rtl/ick_bus_slave.sv
module ick_bus_slave
    import ick_pkg::*;
#(
    parameter int                   WORD_W      = 16,
    parameter int                   BYTE_W      = 8,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [ADDR_BITS-1:0] BASE_LO     = 8'd128,
    parameter logic [ADDR_BITS-1:0] BASE_HI     = 8'd132
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_i,
    input  logic              cl_i,
    input  logic              d_i,
    output logic              d_pull_low_o,
    input  logic              opt_strap_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              cmd_commit_o,
    output logic [1:0]        cmd_kind_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_long_o
);

    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam int BI_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] N_ADDR  = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] N_SHORT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(WORD_W);

    lines_t lvl, rise, fall, raw;
    assign raw = '{dat: d_i, cl: cl_i, id: id_i};

    ick_line_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    st_e               st_q;
    cmd_e              kind_q;
    cmd_e              match_kind;
    logic [NUM_CMDS-1:0] hit_vec;
    logic              sh_clr, sh_take;
    logic [WORD_W-1:0] sh_word;
    logic [CNT_W-1:0]  sh_cnt;

    assign sh_clr  = (fall.id && (st_q == ST_IDLE || st_q == ST_SKIP))
                   || (rise.id && st_q == ST_ADDR);
    assign sh_take = rise.cl && (st_q == ST_ADDR || st_q == ST_DATA);

    ick_shift_unit #(.W(WORD_W)) shift_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (sh_clr),
        .take_i (sh_take),
        .bit_i  (lvl.dat),
        .word_o (sh_word),
        .cnt_o  (sh_cnt)
    );

    ick_addr_match #(.BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) match_i (
        .addr_i  (sh_word[ADDR_BITS-1:0]),
        .strap_i (opt_strap_i),
        .hit_o   (hit_vec),
        .kind_o  (match_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            kind_q       <= CMD_NONE;
            cmd_commit_o <= 1'b0;
            cmd_kind_o   <= CMD_NONE;
            rx_word_o    <= '0;
            rx_long_o    <= 1'b0;
        end else begin
            cmd_commit_o <= 1'b0;
            case (st_q)
                ST_IDLE, ST_SKIP: begin
                    if (fall.id) st_q <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (rise.id) begin
                        if (sh_cnt == N_ADDR && match_kind != CMD_NONE) begin
                            st_q   <= ST_DATA;
                            kind_q <= match_kind;
                        end else begin
                            st_q <= ST_SKIP;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall.id) st_q <= ST_ENDP;
                end
                ST_ENDP: begin
                    if (rise.id) begin
                        st_q <= ST_IDLE;
                        if (sh_cnt == N_SHORT || sh_cnt == N_LONG) begin
                            cmd_commit_o <= 1'b1;
                            cmd_kind_o   <= kind_q;
                            rx_word_o    <= sh_word;
                            rx_long_o    <= (sh_cnt == N_LONG);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // open-drain read driver: only ever pulls low, first byte only
    assign d_pull_low_o = (st_q == ST_DATA) && (kind_q == CMD_READ)
                        && (sh_cnt < N_SHORT) && !rd_byte_i[sh_cnt[BI_W-1:0]];

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!d_pull_low_o && !cmd_commit_o)); // R1

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_commit_o |=> !cmd_commit_o); // R5

    AST_COMMIT_AFTER_IDENT: assert property (@(posedge clk) disable iff (rst)
        cmd_commit_o |-> $past(rise.id)); // R5

    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
        !cmd_commit_o |-> $stable(rx_word_o)); // R5

    AST_PULL_IDENT_HIGH: assert property (@(posedge clk) disable iff (rst)
        d_pull_low_o |-> $past(lvl.id)); // R6

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SKIP) |-> (!d_pull_low_o && !cmd_commit_o)); // R7

endmodule

// File: tb/ick_bus_slave_tb_top.sv
module ick_bus_slave_tb_top;

    localparam int H = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       m_id = 1'b1, m_cl = 1'b1, m_d = 1'b1;
    logic       strap = 1'b0;
    logic [7:0] rd_byte = 8'hFF;
    logic       pull, commit, rx_long;
    logic [1:0] kind;
    logic [15:0] rx_word;
    wire        line_d = m_d & ~pull;

    ick_bus_slave dut_i (
        .clk          (clk),
        .rst          (rst),
        .id_i         (m_id),
        .cl_i         (m_cl),
        .d_i          (line_d),
        .d_pull_low_o (pull),
        .opt_strap_i  (strap),
        .rd_byte_i    (rd_byte),
        .cmd_commit_o (commit),
        .cmd_kind_o   (kind),
        .rx_word_o    (rx_word),
        .rx_long_o    (rx_long)
    );

    int n_chk = 0, n_bad = 0;
    int commits = 0, pulls = 0;
    always @(posedge clk) begin
        if (commit) commits <= commits + 1;
        if (pull)   pulls   <= pulls + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic s);
        m_cl = 1'b0; m_d = b;
        half();
        s = line_d;
        m_cl = 1'b1;
        half();
    endtask

    // na address clocks, nd data clocks; optional pause / reset before data bit
    task automatic txn(input logic [7:0] a, input int na, input logic [15:0] dat,
                       input int nd, input int pause_at, input int rst_at,
                       output logic [15:0] got);
        logic s;
        got = 16'hFFFF;
        m_id = 1'b0;
        half();
        for (int i = 0; i < na; i++) send_bit(a[i % 8], s);
        m_d = 1'b1;
        m_id = 1'b1;
        half();
        for (int i = 0; i < nd; i++) begin
            if (i == pause_at) repeat (2000) @(negedge clk);
            if (i == rst_at) begin
                rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
            end
            send_bit(dat[i], s);
            got[i] = s;
        end
        m_d = 1'b1;
        m_id = 1'b0;
        half();
        m_id = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    function automatic int exp_kind(input int a, input logic st);
        int b;
        b = st ? 132 : 128;
        if (a == b)     return 1;
        if (a == b + 1) return 2;
        if (a == b + 3) return 3;
        return 0;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] got;
        int c0, p0, ek;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(pull == 1'b0, "R1 pull", pull, 0);
        chk(commit == 1'b0 && commits == 0, "R1 commit", commits, 0);
        chk(kind == 2'd0, "R1 kind", kind, 0);
        chk(rx_word == 16'h0 && rx_long == 1'b0, "R1 word", rx_word, 0);

        // R2 / R3 / R7 sweep of every address under both straps, 8-bit data
        rd_byte = 8'hFF;
        for (int sv = 0; sv < 2; sv++) begin
            strap = sv[0];
            for (int a = 0; a < 256; a++) begin
                logic [15:0] d;
                d = 16'((a ^ 8'h5A) & 8'hFF);
                c0 = commits; p0 = pulls;
                txn(8'(a), 8, d, 8, -1, -1, got);
                ek = exp_kind(a, strap);
                if (ek == 0) begin
                    chk(commits == c0, sv ? "R3 unrecognised" : "R7 unrecognised", commits - c0, 0);
                    chk(pulls == p0, "R7 no pull", pulls - p0, 0);
                end else begin
                    chk(commits == c0 + 1, sv ? "R3 commit" : "R2 commit", commits - c0, 1);
                    chk(kind == 2'(ek), sv ? "R3 kind" : "R2 kind", kind, ek);
                    chk(rx_word == d && rx_long == 1'b0, "R4 short word", rx_word, d);
                end
            end
        end

        // R4 16-bit program
        strap = 1'b0;
        txn(8'd131, 8, 16'hA5C3, 16, -1, -1, got);
        chk(rx_word == 16'hA5C3, "R4 long word", rx_word, 16'hA5C3);
        chk(rx_long == 1'b1 && kind == 2'd3, "R4 long flag", rx_long, 1);

        // R6 reads, 16-clock and 8-clock forms
        for (int v = 0; v < 16; v++) begin
            logic [7:0] rb;
            rb = 8'((v * 37) ^ 8'hC6);
            rd_byte = rb;
            strap = v[0];
            txn(strap ? 8'd133 : 8'd129, 8, 16'hFFFF, 16, -1, -1, got);
            chk(got[7:0] == rb, "R6 read byte", got[7:0], rb);
            chk(got[15:8] == 8'hFF, "R6 released second byte", got[15:8], 8'hFF);
            chk(kind == 2'd2 && rx_long == 1'b1, "R6 read commit", kind, 2);
            txn(strap ? 8'd133 : 8'd129, 8, 16'hFFFF, 8, -1, -1, got);
            chk(got[7:0] == rb, "R6 single byte read", got[7:0], rb);
        end
        rd_byte = 8'hFF;
        repeat (3) @(negedge clk);
        chk(pull == 1'b0, "R6 idle release", pull, 0);

        // R8 long pause inside data phase
        strap = 1'b0;
        c0 = commits;
        txn(8'd131, 8, 16'h0096, 8, 5, -1, got);
        chk(commits == c0 + 1 && rx_word == 16'h0096, "R8 pause", rx_word, 16'h0096);

        // R10 wrong lengths
        c0 = commits;
        txn(8'd131, 8, 16'h001F, 5, -1, -1, got);
        chk(commits == c0, "R10 five data bits", commits - c0, 0);
        txn(8'd131, 7, 16'h0011, 8, -1, -1, got);
        chk(commits == c0, "R10 seven address bits", commits - c0, 0);
        txn(8'd131, 9, 16'h0011, 8, -1, -1, got);
        chk(commits == c0, "R10 nine address bits", commits - c0, 0);

        // R7 unrecognised address while read byte is all zeros
        rd_byte = 8'h00;
        p0 = pulls;
        txn(8'd130, 8, 16'hFFFF, 16, -1, -1, got);
        chk(pulls == p0 && got == 16'hFFFF, "R7 line released", got, 16'hFFFF);
        chk(commits == c0, "R7 no commit", commits - c0, 0);
        txn(8'd129, 8, 16'hFFFF, 8, -1, -1, got);
        chk(got[7:0] == 8'h00 && commits == c0 + 1, "R7 next txn recovers", got[7:0], 0);
        rd_byte = 8'hFF;

        // R9 reset mid-transaction
        c0 = commits;
        txn(8'd131, 8, 16'h3C3C, 16, -1, 6, got);
        chk(commits == c0, "R9 aborted no commit", commits - c0, 0);
        chk(kind == 2'd0 && rx_word == 16'h0, "R9 outputs cleared", rx_word, 0);
        txn(8'd128, 8, 16'h01FF, 16, -1, -1, got);
        chk(commits == c0 + 1 && kind == 2'd1 && rx_word == 16'h01FF, "R9 resume", rx_word, 16'h01FF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule